// File: doc/BRIEF.md
# Tagged Byte FIFO with Run-Length Read Expansion

This block buffers bytes between a host and a parallel-port engine. Each entry holds eight data bits and a ninth tag bit. The host writes through one of three write ports, all of which share the same storage. When the host reads through the expanding read port, the block decompresses run-length encoded data. An entry whose tag and data bit 7 are both low is a repeat count. The block takes that count in and does not hand it to the host. It then returns the following byte the requested number of times before it moves past that byte.

A second read port returns entries raw, with no expansion, so the stored contents can be checked directly. Reading an empty FIFO is an under-run. It does not produce stale memory contents: the read output keeps the last byte that was delivered, and the empty flag stays correct.

The read output comes from a register. A byte selected by a read request appears on `rd_data` one clock after that request. The full and empty flags follow the pointers, so they change in the same cycle as the write or read that moves them.

Top module: `ecp_rle_fifo`

## Requirements
- R1: A synchronous active-low reset clears both pointers, the repeat counter and the read output register. After reset, `empty`=1, `full`=0 and `rd_data`=0, and no repeat pending from before the reset has any effect.
- R2: The FIFO holds DEPTH entries (16 by default) and `full` rises when the last entry is written. A write while `full`=1 is discarded and the stored entries do not change, even if a read happens in the same cycle. A write while `full`=0 is stored.
- R3: Write port `wr_port` selects the write source: 2'b00 is the compatibility port and 2'b01 is the data port, and both store the byte with tag=1. 2'b10 is the test port and stores tag = `wr_tag`. 2'b11 writes nothing.
- R4: An expanding read (`rd_port`=0) of a head entry with tag=1 removes that entry and shows its byte on `rd_data` one clock later. Entries come out in write order.
- R5: An expanding read of a head entry with tag=0 and data bit 7=0 removes that entry and loads the repeat counter with its bits 6:0 plus one. `rd_data` keeps its previous value for that read.
- R6: While the counter is nonzero, each expanding read returns the head byte and decrements the counter. The head entry is removed only on the read that takes the counter to zero, so the byte is delivered count+1 times in total.
- R7: A head entry with tag=0 and data bit 7=1 is ordinary data on an expanding read.
- R8: A read of either kind while `empty`=1 leaves `rd_data` unchanged, does not change the counter, and keeps `empty`=1 unless a write arrives.
- R9: A test read (`rd_port`=1) removes the head entry and returns its byte unchanged, whatever the tag, and leaves the counter unchanged.
- R10: `empty` reflects only the stored entries. While repeats are pending on a stored byte, `empty`=0 until the final repeat removes it. A write and a read in the same cycle are both serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write request |
| wr_port | input | 2 | Write source select (00 compat, 01 data, 10 test, 11 none) |
| wr_tag | input | 1 | Tag bit used by test-port writes |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Host read request |
| rd_port | input | 1 | Read select (0 expanding, 1 raw test) |
| rd_data | output | 8 | Last byte delivered to the host |
| full | output | 1 | FIFO holds DEPTH entries |
| empty | output | 1 | FIFO holds no entries |

## Verification
Some properties are checked on every cycle against the pointer level, the repeat counter and the head entry. These are: full and empty are never set together, a write while full leaves the level unchanged, and an under-run holds the output. They also check that consuming a count entry loads the counter without changing the output, that a pending repeat decrements the counter without removing an entry, and that plain and raw reads deliver the head byte. Some behaviours can only be shown by the bench's scenarios. These are the tag each write port stores, the exact number of repeats seen at the port, the write-order sequencing, and the fact that a discarded write never comes out later. The same holds for under-run during a pending repeat and for a reset that wipes a half-consumed run.

// File: rtl/ecp_fifo_pkg.sv
// Package: shared encodings for the tagged-byte FIFO.
// Assumes: write and read selects are decoded only through these enums.
package ecp_fifo_pkg;

    typedef enum logic [1:0] {
        WP_COMPAT = 2'b00,
        WP_DATA   = 2'b01,
        WP_TEST   = 2'b10,
        WP_NONE   = 2'b11
    } wr_port_e;

    typedef enum logic {
        RP_EXPAND = 1'b0,
        RP_RAW    = 1'b1
    } rd_port_e;

endpackage

// File: rtl/ecp_wr_tagger.sv
// Module: turns a host write request into a push of a tagged word.
// Assumes: the data and compatibility ports carry plain data (tag high),
//          the test port carries an explicit tag, and the 11 code is idle.
module ecp_wr_tagger
    import ecp_fifo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              wr_en,
    input  logic [1:0]        wr_port,
    input  logic              wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output logic              push,
    output logic [DATA_W:0]   push_word
);

    // Decode the write source into a push request and the stored tag.
    always_comb begin
        push      = 1'b0;
        push_word = {1'b1, wr_data};
        case (wr_port_e'(wr_port))
            WP_COMPAT, WP_DATA: push = wr_en;
            WP_TEST: begin
                push      = wr_en;
                push_word = {wr_tag, wr_data};
            end
            default: push = 1'b0;
        endcase
    end

endmodule

// File: rtl/ecp_fifo_store.sv
// Module: circular storage of DEPTH tagged words with wrap-bit pointers.
// Assumes: DEPTH is a power of two; pushes when full and pops when empty
//          are dropped here, so callers may request them freely.
module ecp_fifo_store #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head_word,
    output logic              full,
    output logic              empty,
    output logic [$clog2(DEPTH):0] level
);

    localparam int AW = $clog2(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW:0]       wr_ptr;
    logic [AW:0]       rd_ptr;
    logic              push_ok;
    logic              pop_ok;

    // Flags derived from the pointers: same index with a different wrap bit means full.
    always_comb begin
        empty   = (wr_ptr == rd_ptr);
        full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
        level   = wr_ptr - rd_ptr;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
    end

    // Write the incoming word into the slot addressed by the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr[AW-1:0]] <= push_word;
        end
    end

    // Advance the pointers on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign head_word = mem[rd_ptr[AW-1:0]];

endmodule

// File: rtl/ecp_rle_reader.sv
// Module: read sequencer with run-length expansion and under-run hold.
// Assumes: head_word is valid whenever empty is low; a tag-low entry with
//          data bit 7 low is a repeat count and never reaches the host.
module ecp_rle_reader
    import ecp_fifo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_port,
    input  logic [DATA_W:0]   head_word,
    input  logic              empty,
    output logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] rle_cnt
);

    logic [DATA_W-1:0] cnt_nxt;
    logic [DATA_W-1:0] last_nxt;
    logic [DATA_W-1:0] head_byte;
    logic              head_is_count;

    // Classify the head entry: tag low and top data bit low marks a count.
    always_comb begin
        head_byte     = head_word[DATA_W-1:0];
        head_is_count = !head_word[DATA_W] && !head_word[DATA_W-1];
    end

    // Decide pop, next counter and next output byte for this cycle's read.
    always_comb begin
        pop      = 1'b0;
        cnt_nxt  = rle_cnt;
        last_nxt = rd_data;
        if (rd_en && !empty) begin
            if (rd_port_e'(rd_port) == RP_RAW) begin
                pop      = 1'b1;
                last_nxt = head_byte;
            end else if (rle_cnt != '0) begin
                last_nxt = head_byte;
                cnt_nxt  = rle_cnt - 1'b1;
                pop      = (rle_cnt == {{(DATA_W-1){1'b0}}, 1'b1});
            end else if (head_is_count) begin
                pop     = 1'b1;
                cnt_nxt = {1'b0, head_byte[DATA_W-2:0]} + 1'b1;
            end else begin
                pop      = 1'b1;
                last_nxt = head_byte;
            end
        end
    end

    // Hold the repeat counter and the last delivered byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rle_cnt <= '0;
            rd_data <= '0;
        end else begin
            rle_cnt <= cnt_nxt;
            rd_data <= last_nxt;
        end
    end

endmodule

// File: rtl/ecp_rle_fifo.sv
// Module: top of the tagged-byte FIFO with run-length read expansion.
// Assumes: one host write and one host read may be requested per cycle;
//          rd_data is registered and follows a read by one clock.
module ecp_rle_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_port,
    input  logic              wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_port,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);

    localparam int WORD_W = DATA_W + 1;
    localparam int AW     = $clog2(DEPTH);

    logic              push;
    logic [WORD_W-1:0] push_word;
    logic              pop;
    logic [WORD_W-1:0] head_word;
    logic [AW:0]       level;
    logic [DATA_W-1:0] rle_cnt;

    ecp_wr_tagger #(.DATA_W(DATA_W)) u_tagger (
        .wr_en     (wr_en),
        .wr_port   (wr_port),
        .wr_tag    (wr_tag),
        .wr_data   (wr_data),
        .push      (push),
        .push_word (push_word)
    );

    ecp_fifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .pop       (pop),
        .head_word (head_word),
        .full      (full),
        .empty     (empty),
        .level     (level)
    );

    ecp_rle_reader #(.DATA_W(DATA_W)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_port   (rd_port),
        .head_word (head_word),
        .empty     (empty),
        .pop       (pop),
        .rd_data   (rd_data),
        .rle_cnt   (rle_cnt)
    );

endmodule

// File: rtl/ecp_rle_fifo_chk.sv
// Module: property checker for ecp_rle_fifo, attached by bind.
// Assumes: it observes the top's ports plus level, counter and head word.
module ecp_rle_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              rd_port,
    input logic [DATA_W-1:0] rd_data,
    input logic              full,
    input logic              empty,
    input logic [$clog2(DEPTH):0] level,
    input logic [DATA_W-1:0] rle_cnt,
    input logic [DATA_W:0]   head_word
);

    // R1: the first cycle out of reset shows the cleared state.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty && !full && rd_data == '0 && rle_cnt == '0));

    // R2: full and empty never hold together.
    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R2: a write while full and without a read leaves the level unchanged.
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && level == $past(level)));

    // R4: an expanding read of tagged data delivers the head byte.
    p_plain_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_port && !empty && rle_cnt == '0 && head_word[DATA_W])
        |=> (rd_data == $past(head_word[DATA_W-1:0])));

    // R5: consuming a count entry loads the counter and holds the output.
    p_count_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_port && !empty && rle_cnt == '0
         && !head_word[DATA_W] && !head_word[DATA_W-1])
        |=> ($stable(rd_data)
             && rle_cnt == {1'b0, $past(head_word[DATA_W-2:0])} + 1'b1));

    // R6: a pending repeat decrements the counter and keeps the entry.
    p_repeat_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_port && !empty && rle_cnt > 1 && !wr_en)
        |=> (level == $past(level) && rle_cnt == $past(rle_cnt) - 1'b1));

    // R8: an under-run holds the output byte and the counter.
    p_underrun_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> ($stable(rd_data) && $stable(rle_cnt)));

    // R8: an under-run without a write keeps the FIFO empty.
    p_underrun_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> empty);

    // R9: a raw read returns the head byte regardless of tag.
    p_raw_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_port && !empty)
        |=> (rd_data == $past(head_word[DATA_W-1:0]) && $stable(rle_cnt)));

endmodule

bind ecp_rle_fifo ecp_rle_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_port   (rd_port),
    .rd_data   (rd_data),
    .full      (full),
    .empty     (empty),
    .level     (level),
    .rle_cnt   (rle_cnt),
    .head_word (head_word)
);

// File: tb/tb_ecp_rle_fifo.sv
module tb_ecp_rle_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_port = 2'b00;
    logic       wr_tag = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       rd_port = 1'b0;
    logic [7:0] rd_data;
    logic       full;
    logic       empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ecp_rle_fifo dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
        .wr_tag(wr_tag), .wr_data(wr_data), .rd_en(rd_en), .rd_port(rd_port),
        .rd_data(rd_data), .full(full), .empty(empty)
    );

    typedef struct packed {
        logic       is_rd;
        logic [1:0] port;
        logic       tag;
        logic [7:0] data;
        logic [7:0] exp_data;
        logic       exp_empty;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'b01, 1'b0, 8'h11, 8'h00, 1'b0, 4'd3},  // R3 data port
        '{1'b0, 2'b00, 1'b0, 8'h05, 8'h00, 1'b0, 4'd3},  // R3 compat port, tag high
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h11, 1'b0, 4'd4},  // R4 order
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h05, 1'b1, 4'd3},  // R3 not a count
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h05, 1'b1, 4'd8},  // R8 under-run
        '{1'b0, 2'b10, 1'b0, 8'h02, 8'h05, 1'b0, 4'd3},  // count of 2
        '{1'b0, 2'b01, 1'b0, 8'h7A, 8'h05, 1'b0, 4'd3},
        '{1'b0, 2'b01, 1'b0, 8'h33, 8'h05, 1'b0, 4'd3},
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h05, 1'b0, 4'd5},  // R5 count consumed
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h7A, 1'b0, 4'd6},  // R6 1st
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h7A, 1'b0, 4'd6},  // R6 2nd
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h7A, 1'b0, 4'd6},  // R6 3rd
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h33, 1'b1, 4'd6},  // R6 advanced
        '{1'b0, 2'b10, 1'b0, 8'h85, 8'h33, 1'b0, 4'd7},
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h85, 1'b1, 4'd7},  // R7 plain
        '{1'b0, 2'b10, 1'b0, 8'h01, 8'h85, 1'b0, 4'd5},
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h85, 1'b1, 4'd5},  // R5 count of 1
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h85, 1'b1, 4'd8},  // R8 under-run, run pending
        '{1'b0, 2'b01, 1'b0, 8'h66, 8'h85, 1'b0, 4'd10},
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h66, 1'b0, 4'd10}, // R10 entry kept
        '{1'b1, 2'b00, 1'b0, 8'h00, 8'h66, 1'b1, 4'd10}, // R10 removed
        '{1'b0, 2'b10, 1'b0, 8'h03, 8'h66, 1'b0, 4'd9},
        '{1'b1, 2'b01, 1'b0, 8'h00, 8'h03, 1'b1, 4'd9},  // R9 raw count byte
        '{1'b0, 2'b11, 1'b0, 8'h99, 8'h03, 1'b1, 4'd3},  // R3 idle code
        '{1'b1, 2'b01, 1'b0, 8'h00, 8'h03, 1'b1, 4'd8}   // R8 raw under-run
    };

    task automatic check(input string req, input logic [7:0] act_d, input logic [7:0] exp_d,
                         input logic act_e, input logic exp_e, input logic act_f, input logic exp_f);
        checks++;
        if (act_d !== exp_d || act_e !== exp_e || act_f !== exp_f) begin
            fails++;
            $display("FAIL %s: rd_data=%h empty=%b full=%b expected rd_data=%h empty=%b full=%b",
                     req, act_d, act_e, act_f, exp_d, exp_e, exp_f);
        end
    endtask

    // Drive one cycle of requests at a falling edge; outputs settle by the next one.
    task automatic step(input logic we, input logic [1:0] wp, input logic wt, input logic [7:0] wd,
                        input logic re, input logic rp);
        wr_en = we; wr_port = wp; wr_tag = wt; wr_data = wd; rd_en = re; rd_port = rp;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset", rd_data, 8'h00, empty, 1'b1, full, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(!VEC[i].is_rd, VEC[i].port, VEC[i].tag, VEC[i].data, VEC[i].is_rd, VEC[i].port[0]);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), rd_data, VEC[i].exp_data,
                  empty, VEC[i].exp_empty, full, 1'b0);
        end

        // R2: fill to depth, then a write while full must vanish.
        for (int i = 0; i < 16; i++) step(1'b1, 2'b01, 1'b0, 8'h20 + 8'(i), 1'b0, 1'b0);
        check("R2 full after 16", rd_data, 8'h03, empty, 1'b0, full, 1'b1);
        step(1'b1, 2'b01, 1'b0, 8'hEE, 1'b0, 1'b0);
        check("R2 write when full", rd_data, 8'h03, empty, 1'b0, full, 1'b1);
        // R2 / R10: write and read together while full: write dropped, read served.
        step(1'b1, 2'b01, 1'b0, 8'hDD, 1'b1, 1'b1);
        check("R2 full wr+rd", rd_data, 8'h20, empty, 1'b0, full, 1'b0);
        for (int i = 1; i < 16; i++) begin
            step(1'b0, 2'b00, 1'b0, 8'h00, 1'b1, 1'b1);
            check($sformatf("R2 drain %0d", i), rd_data, 8'h20 + 8'(i),
                  empty, (i == 15), full, 1'b0);
        end
        step(1'b0, 2'b00, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R2 dropped bytes absent", rd_data, 8'h2F, empty, 1'b1, full, 1'b0);

        // R10: simultaneous write and read on a one-entry FIFO.
        step(1'b1, 2'b01, 1'b0, 8'h51, 1'b0, 1'b0);
        step(1'b1, 2'b01, 1'b0, 8'h52, 1'b1, 1'b0);
        check("R10 wr+rd same cycle", rd_data, 8'h51, empty, 1'b0, full, 1'b0);
        step(1'b0, 2'b00, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R10 second byte", rd_data, 8'h52, empty, 1'b1, full, 1'b0);

        // R1: a reset in the middle of a run clears the pending repeats.
        step(1'b1, 2'b10, 1'b0, 8'h05, 1'b0, 1'b0);
        step(1'b0, 2'b00, 1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b1, 2'b01, 1'b0, 8'h77, 1'b0, 1'b0);
        do_reset();
        check("R1 mid-run reset", rd_data, 8'h00, empty, 1'b1, full, 1'b0);
        step(1'b1, 2'b01, 1'b0, 8'h44, 1'b0, 1'b0);
        step(1'b1, 2'b01, 1'b0, 8'h45, 1'b0, 1'b0);
        step(1'b0, 2'b00, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R1 no stale repeat a", rd_data, 8'h44, empty, 1'b0, full, 1'b0);
        step(1'b0, 2'b00, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R1 no stale repeat b", rd_data, 8'h45, empty, 1'b1, full, 1'b0);

        finish_run();
    end

endmodule